// File: doc/BRIEF.md
# Sigma-Delta Converter Serial Host Controller

This block is the host side of a serial link to a multiplexed sigma-delta converter. On that converter one output pin does two jobs: it carries serial read data during a transfer, and at other times it signals that a conversion has finished by going low. The controller drives chip select, the serial clock and the serial data-in line. It watches the shared line for a fresh ready indication and then fetches the 32-bit result on its own. It also runs register reads and writes that a local command port asks for.

Every transfer starts with an 8-bit command byte. A 6-bit field in that byte picks the target register, and one bit picks read or write. A data phase of 8, 16, 24 or 32 bits follows, and its length is set by the register address. Read data, whether a conversion result or a register value, leaves the block on a one-cycle valid strobe with a flag that says which kind it is. The serial clock is the system clock divided by an even parameter. A second parameter ties chip select low for 3-wire wiring.

Top module: `sdhc_host`

## Requirements
- R1: Once reset is released, the outputs hold these values: sclk_o=1, mosi_o=1, rsp_valid_o=0, cmd_ready_o=1, and cs_n_o=1 when THREE_WIRE=0.
- R2: Each serial bit lasts CLK_DIV system clocks. sclk_o is low for the first CLK_DIV/2 of them and high for the rest. sclk_o stays high between transfers and whenever cs_n_o is high.
- R3: A transfer starts with the command byte, sent MSB first. Bit 7 is 0, bit 6 is 1 for a read and 0 for a write, and bits 5:0 hold the register address. mosi_o changes only in the cycle where sclk_o falls.
- R4: miso_rdy_i is sampled when sclk_o rises. Read data arrives MSB first and is right-justified in rsp_data_o, with the unused upper bits set to zero. mosi_o is 0 during the data phase of a read.
- R5: The data-phase length depends on the address: 8 bits for 0x00, 32 bits for 0x04, 24 bits for 0x30 to 0x3F, and 16 bits for every other address.
- R6: A write sends the low data-phase bytes of cmd_wdata_i, MSB first. A write produces no rsp_valid_o.
- R7: While waiting for a result with chip select low, the controller starts a read of address 0x04 only after it has seen the shared line high and then low. A line that is already low when waiting begins does not start a read.
- R8: rsp_valid_o is a single-cycle pulse. rsp_conv_o is 1 for a conversion result and 0 for a commanded read.
- R9: If a command and a ready indication arrive in the same cycle, the command is served first. Afterwards the controller returns to waiting and needs a new high-to-low edge on the line before it reads a result.
- R10: With THREE_WIRE=0, cs_n_o is low whenever the controller is not idle. With THREE_WIRE=1, cs_n_o is always 0.
- R11: cmd_ready_o is 1 exactly when the controller is idle or waiting for a result. A command is taken on a cycle where cmd_valid_i and cmd_ready_o are both 1.
- R12: Clearing conv_en_i while waiting returns the controller to idle and raises cs_n_o. A low level on the line while idle starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_en_i | input | 1 | Keep waiting for conversion results and fetching them |
| cmd_valid_i | input | 1 | Register command request |
| cmd_ready_o | output | 1 | Command accepted on this cycle if valid |
| cmd_write_i | input | 1 | 1 = register write, 0 = register read |
| cmd_addr_i | input | 6 | Register address |
| cmd_wdata_i | input | 32 | Write data, right-justified |
| rsp_valid_o | output | 1 | One-cycle strobe for read data |
| rsp_conv_o | output | 1 | Strobed word is a conversion result |
| rsp_data_o | output | 32 | Read word, right-justified |
| cs_n_o | output | 1 | Converter chip select, active low |
| sclk_o | output | 1 | Serial clock, idles high |
| mosi_o | output | 1 | Serial data to the converter |
| miso_rdy_i | input | 1 | Shared serial data out / ready line |

## Verification
The hardest case to reach is a command and a ready edge landing on the same clock edge while the controller is already armed. The bench first holds the line high in the waiting state so that the detector sees a high level. Then, on one falling clock edge, it raises cmd_valid_i and pulls the line low together. A stale-low line at the moment waiting begins is created the same way: the line is driven low before conv_en_i is set. A behavioural model of the serial timing is compared against the pins on every clock, and a converter model replays response words and records the bits sent on mosi_o.

// File: rtl/sdhc_pkg.sv
// Shared constants, state encoding and frame helpers for the serial host.
// Assumes a command byte of {0, read, addr[5:0]} and data phases of whole bytes.
package sdhc_pkg;
    localparam int ADDR_W  = 6;
    localparam int WORD_W  = 32;
    localparam int CMD_W   = 8;
    localparam int FRAME_W = CMD_W + WORD_W;
    localparam int BITS_W  = $clog2(FRAME_W + 1);

    localparam logic [ADDR_W-1:0] REG_STATUS = 6'h00;
    localparam logic [ADDR_W-1:0] REG_RESULT = 6'h04;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_RDY,
        ST_CMD,
        ST_DATA,
        ST_DONE
    } ctl_state_t;

    // Data-phase length in bytes for a register address.
    function automatic logic [2:0] data_bytes(input logic [ADDR_W-1:0] addr);
        if (addr == REG_STATUS)       return 3'd1;
        else if (addr == REG_RESULT)  return 3'd4;
        else if (addr[5:4] == 2'b11)  return 3'd3;
        else                          return 3'd2;
    endfunction

    // Command byte: top bit zero, then direction, then address.
    function automatic logic [CMD_W-1:0] comm_byte(input logic rd, input logic [ADDR_W-1:0] addr);
        return {1'b0, rd, addr};
    endfunction
endpackage

// File: rtl/sdhc_rdy_watch.sv
// Ready-edge detector for the shared data-out/ready line.
// Reports a hit only after it has seen the line high and then low while
// watch_i is held; a line already low when watching begins is ignored.
// Assumes line_i is synchronous to clk.
module sdhc_rdy_watch (
    input  logic clk,
    input  logic rst_n,
    input  logic watch_i,
    input  logic line_i,
    output logic hit_o
);
    logic seen_high_q;

    // Remember a high level while watching; forget it once watching stops.
    always_ff @(posedge clk) begin
        if (!rst_n) seen_high_q <= 1'b0;
        else        seen_high_q <= watch_i ? (seen_high_q | line_i) : 1'b0;
    end

    assign hit_o = watch_i & seen_high_q & ~line_i;
endmodule

// File: rtl/sdhc_shifter.sv
// Serial bit engine: sends one frame MSB first and drives mosi on the falling
// sclk edge. After the command byte it samples miso on the rising edge.
// Each bit takes CLK_DIV clocks and sclk idles high. Assumes CLK_DIV is even and >= 2.
module sdhc_shifter
    import sdhc_pkg::*;
#(
    parameter int CLK_DIV = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [FRAME_W-1:0] frame_i,
    input  logic [BITS_W-1:0]  nbits_i,
    input  logic               miso_i,
    output logic               in_data_o,
    output logic               done_o,
    output logic               sclk_o,
    output logic               mosi_o,
    output logic [WORD_W-1:0]  rx_o
);
    localparam int HALF  = CLK_DIV / 2;
    localparam int DIV_W = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;

    logic               busy_q;
    logic [DIV_W-1:0]   div_q;
    logic [BITS_W-1:0]  bit_q;
    logic [BITS_W-1:0]  nbits_q;
    logic [FRAME_W-1:0] tx_q;

    // Load a frame, then step the divider and bit counter until the frame ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            div_q   <= '0;
            bit_q   <= '0;
            nbits_q <= '0;
            tx_q    <= '0;
            rx_o    <= '0;
            sclk_o  <= 1'b1;
            mosi_o  <= 1'b1;
            done_o  <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (!busy_q) begin
                if (start_i) begin
                    busy_q  <= 1'b1;
                    tx_q    <= frame_i;
                    nbits_q <= nbits_i;
                    bit_q   <= '0;
                    div_q   <= '0;
                    rx_o    <= '0;
                end
            end else begin
                if (div_q == '0) begin
                    sclk_o <= 1'b0;
                    mosi_o <= tx_q[FRAME_W-1];
                    tx_q   <= {tx_q[FRAME_W-2:0], 1'b0};
                end
                if (div_q == DIV_W'(HALF)) begin
                    sclk_o <= 1'b1;
                    if (bit_q >= BITS_W'(CMD_W)) rx_o <= {rx_o[WORD_W-2:0], miso_i};
                end
                if (div_q == DIV_W'(CLK_DIV - 1)) begin
                    div_q <= '0;
                    if (bit_q == nbits_q - BITS_W'(1)) begin
                        busy_q <= 1'b0;
                        done_o <= 1'b1;
                    end else begin
                        bit_q <= bit_q + BITS_W'(1);
                    end
                end else begin
                    div_q <= div_q + DIV_W'(1);
                end
            end
        end
    end

    assign in_data_o = (bit_q >= BITS_W'(CMD_W));
endmodule

// File: rtl/sdhc_host.sv
// Host controller for a sigma-delta converter whose data-out pin doubles as an
// active-low ready flag. It serves register commands, and when conv_en_i is set
// it waits for a fresh ready edge and then reads the 32-bit result.
// Commands take priority over a ready edge. Assumes miso_rdy_i is synchronous to clk.
module sdhc_host
    import sdhc_pkg::*;
#(
    parameter int CLK_DIV    = 4,
    parameter bit THREE_WIRE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_en_i,
    input  logic              cmd_valid_i,
    output logic              cmd_ready_o,
    input  logic              cmd_write_i,
    input  logic [ADDR_W-1:0] cmd_addr_i,
    input  logic [WORD_W-1:0] cmd_wdata_i,
    output logic              rsp_valid_o,
    output logic              rsp_conv_o,
    output logic [WORD_W-1:0] rsp_data_o,
    output logic              cs_n_o,
    output logic              sclk_o,
    output logic              mosi_o,
    input  logic              miso_rdy_i
);
    ctl_state_t         st_q, st_d;
    logic               launch, launch_conv, launch_rd;
    logic [ADDR_W-1:0]  launch_addr;
    logic [2:0]         launch_bytes;
    logic [BITS_W-1:0]  launch_bits;
    logic [FRAME_W-1:0] launch_frame;
    logic               rd_q, conv_q;
    logic               rdy_hit, sh_in_data, sh_done;
    logic [WORD_W-1:0]  sh_rx;

    assign cmd_ready_o = (st_q == ST_IDLE) || (st_q == ST_WAIT_RDY);

    sdhc_rdy_watch u_rdy (
        .clk     (clk),
        .rst_n   (rst_n),
        .watch_i ((st_q == ST_WAIT_RDY) && !cs_n_o),
        .line_i  (miso_rdy_i),
        .hit_o   (rdy_hit)
    );

    // Next state and transfer launch; a command wins over a ready edge.
    always_comb begin
        st_d        = st_q;
        launch      = 1'b0;
        launch_conv = 1'b0;
        unique case (st_q)
            ST_IDLE, ST_WAIT_RDY: begin
                if (cmd_valid_i) begin
                    launch = 1'b1;
                    st_d   = ST_CMD;
                end else if (rdy_hit) begin
                    launch      = 1'b1;
                    launch_conv = 1'b1;
                    st_d        = ST_CMD;
                end else begin
                    st_d = conv_en_i ? ST_WAIT_RDY : ST_IDLE;
                end
            end
            ST_CMD:  if (sh_in_data) st_d = ST_DATA;
            ST_DATA: if (sh_done)    st_d = ST_DONE;
            ST_DONE: st_d = conv_en_i ? ST_WAIT_RDY : ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // Frame assembly: command byte, then write data left-aligned or zeros for a read.
    always_comb begin
        launch_addr  = launch_conv ? REG_RESULT : cmd_addr_i;
        launch_rd    = launch_conv | ~cmd_write_i;
        launch_bytes = data_bytes(launch_addr);
        launch_bits  = BITS_W'({launch_bytes, 3'b000}) + BITS_W'(CMD_W);
        launch_frame = {comm_byte(launch_rd, launch_addr),
                        launch_rd ? '0 :
                        (cmd_wdata_i << (BITS_W'(WORD_W) - BITS_W'({launch_bytes, 3'b000})))};
    end

    sdhc_shifter #(.CLK_DIV(CLK_DIV)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (launch),
        .frame_i   (launch_frame),
        .nbits_i   (launch_bits),
        .miso_i    (miso_rdy_i),
        .in_data_o (sh_in_data),
        .done_o    (sh_done),
        .sclk_o    (sclk_o),
        .mosi_o    (mosi_o),
        .rx_o      (sh_rx)
    );

    // State, chip select and the read-data strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= ST_IDLE;
            cs_n_o      <= !THREE_WIRE;
            rd_q        <= 1'b0;
            conv_q      <= 1'b0;
            rsp_valid_o <= 1'b0;
            rsp_conv_o  <= 1'b0;
            rsp_data_o  <= '0;
        end else begin
            st_q        <= st_d;
            cs_n_o      <= THREE_WIRE ? 1'b0 : (st_d == ST_IDLE);
            rsp_valid_o <= (st_q == ST_DATA) && sh_done && rd_q;
            if (launch) begin
                rd_q   <= launch_rd;
                conv_q <= launch_conv;
            end
            if ((st_q == ST_DATA) && sh_done && rd_q) begin
                rsp_data_o <= sh_rx;
                rsp_conv_o <= conv_q;
            end
        end
    end
endmodule

// File: rtl/sdhc_host_chk.sv
// Protocol checker for sdhc_host, bound to every instance.
module sdhc_host_chk (
    input logic clk,
    input logic rst_n,
    input logic cmd_ready_o,
    input logic rsp_valid_o,
    input logic cs_n_o,
    input logic sclk_o,
    input logic mosi_o
);
    // R2
    sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> sclk_o);

    // R3
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_o && $past(sclk_o)) |-> $stable(mosi_o));

    // R8
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |=> !rsp_valid_o);

    // R11
    rsp_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |-> !cmd_ready_o);

    // R10
    sel_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_ready_o |-> !cs_n_o);
endmodule

bind sdhc_host sdhc_host_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_ready_o (cmd_ready_o),
    .rsp_valid_o (rsp_valid_o),
    .cs_n_o      (cs_n_o),
    .sclk_o      (sclk_o),
    .mosi_o      (mosi_o)
);

// File: tb/test_sdhc_host.sv
module test_sdhc_host;
    localparam int DIV  = 4;
    localparam int HALF = DIV / 2;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        conv_en = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_write = 1'b0;
    logic [5:0]  cmd_addr = '0;
    logic [31:0] cmd_wdata = '0;

    logic        cmd_ready, rsp_valid, rsp_conv, cs_n, sclk, mosi;
    logic [31:0] rsp_data;
    logic        b_cmd_ready, b_rsp_valid, b_rsp_conv, b_cs_n, b_sclk, b_mosi;
    logic [31:0] b_rsp_data;
    logic        miso;

    sdhc_host #(.CLK_DIV(DIV), .THREE_WIRE(1'b0)) i_sdhc_host (
        .clk(clk), .rst_n(rst_n), .conv_en_i(conv_en),
        .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready), .cmd_write_i(cmd_write),
        .cmd_addr_i(cmd_addr), .cmd_wdata_i(cmd_wdata),
        .rsp_valid_o(rsp_valid), .rsp_conv_o(rsp_conv), .rsp_data_o(rsp_data),
        .cs_n_o(cs_n), .sclk_o(sclk), .mosi_o(mosi), .miso_rdy_i(miso));

    sdhc_host #(.CLK_DIV(DIV), .THREE_WIRE(1'b1)) i_sdhc_host_3w (
        .clk(clk), .rst_n(rst_n), .conv_en_i(conv_en),
        .cmd_valid_i(cmd_valid), .cmd_ready_o(b_cmd_ready), .cmd_write_i(cmd_write),
        .cmd_addr_i(cmd_addr), .cmd_wdata_i(cmd_wdata),
        .rsp_valid_o(b_rsp_valid), .rsp_conv_o(b_rsp_conv), .rsp_data_o(b_rsp_data),
        .cs_n_o(b_cs_n), .sclk_o(b_sclk), .mosi_o(b_mosi), .miso_rdy_i(miso));

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [39:0] act, input logic [39:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Converter model: replays resp on falling sclk and records mosi on rising sclk.
    logic        rdy_line = 1'b1;
    logic        in_xfer = 1'b0;
    logic        sbit = 1'b1;
    logic [39:0] resp = '0;
    logic [39:0] cap = '0;
    int          fall_n = 0;

    assign miso = cs_n ? 1'b1 : (in_xfer ? sbit : rdy_line);

    always @(negedge sclk) if (cs_n === 1'b0 && fall_n < 40) begin
        in_xfer = 1'b1;
        sbit    = resp[39 - fall_n];
        fall_n++;
    end

    always @(posedge sclk) if (cs_n === 1'b0) cap = {cap[38:0], mosi};

    // Response monitor.
    int          rsp_cnt = 0;
    logic [31:0] last_rsp = '0;
    logic        last_conv = 1'b0;
    always @(negedge clk) if (rst_n && rsp_valid) begin
        rsp_cnt++;
        last_rsp  = rsp_data;
        last_conv = rsp_conv;
    end

    // Behavioural reference model, advanced on every rising clock edge.
    // m_st: 0 idle, 1 waiting, 2 shifting, 3 strobe next, 4 strobe cycle
    int          m_st, m_t, m_nb, m_p, m_b;
    logic [39:0] m_tx;
    logic [31:0] m_rx;
    logic        m_rd, m_conv, m_seen, m_watch, m_seen_nx;
    logic        e_sclk, e_cs, e_mosi, e_rv, e_rc;
    logic [31:0] e_rd;

    function automatic int nbytes_of(input logic [5:0] a);
        if (a == 6'h00) return 1;
        if (a == 6'h04) return 4;
        if (a >= 6'h30) return 3;
        return 2;
    endfunction

    task automatic m_launch(input logic rd, input logic [5:0] a, input logic [31:0] d, input logic cv);
        int n;
        n      = nbytes_of(a);
        m_st   = 2;
        m_t    = 0;
        m_rx   = '0;
        m_rd   = rd;
        m_conv = cv;
        m_nb   = 8 + 8 * n;
        m_tx   = {1'b0, rd, a, 32'h0};
        if (!rd) m_tx[31:0] = d << (32 - 8 * n);
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_seen = 1'b0;
            e_sclk = 1'b1; e_cs = 1'b1; e_mosi = 1'b1;
            e_rv = 1'b0; e_rc = 1'b0; e_rd = '0;
        end else begin
            m_watch   = (m_st == 1) && !e_cs;
            m_seen_nx = m_watch ? (m_seen | miso) : 1'b0;
            e_rv      = 1'b0;
            case (m_st)
                0, 1: begin
                    if (cmd_valid)                         m_launch(!cmd_write, cmd_addr, cmd_wdata, 1'b0);
                    else if (m_watch && m_seen && !miso)   m_launch(1'b1, 6'h04, 32'h0, 1'b1);
                    else                                   m_st = conv_en ? 1 : 0;
                end
                2: begin
                    m_p = m_t % DIV;
                    m_b = m_t / DIV;
                    if (m_p == 0) begin e_sclk = 1'b0; e_mosi = m_tx[39 - m_b]; end
                    if (m_p == HALF) begin
                        e_sclk = 1'b1;
                        if (m_b >= 8) m_rx = {m_rx[30:0], miso};
                    end
                    if (m_p == DIV - 1 && m_b == m_nb - 1) m_st = 3;
                    m_t++;
                end
                3: begin
                    m_st = 4;
                    e_rv = m_rd;
                    if (m_rd) begin e_rd = m_rx; e_rc = m_conv; end
                end
                default: m_st = conv_en ? 1 : 0;
            endcase
            m_seen = m_seen_nx;
            e_cs   = (m_st == 0);
        end
    end

    // Per-clock comparison of both instances against the model.
    always @(negedge clk) if (rst_n && !finished) begin
        chk(sclk === e_sclk, "R2 sclk", 40'(sclk), 40'(e_sclk));
        chk(mosi === e_mosi, "R3 mosi", 40'(mosi), 40'(e_mosi));
        chk(cs_n === e_cs, "R10 cs_n", 40'(cs_n), 40'(e_cs));
        chk(cmd_ready === (m_st <= 1), "R11 cmd_ready", 40'(cmd_ready), 40'(m_st <= 1));
        chk(rsp_valid === e_rv, "R8 rsp_valid", 40'(rsp_valid), 40'(e_rv));
        if (e_rv) begin
            chk(rsp_data === e_rd, "R4 rsp_data", 40'(rsp_data), 40'(e_rd));
            chk(rsp_conv === e_rc, "R8 rsp_conv", 40'(rsp_conv), 40'(e_rc));
        end
        chk(b_cs_n === 1'b0, "R10 three-wire cs_n", 40'(b_cs_n), 40'(0));
        chk(b_sclk === e_sclk, "R10 three-wire sclk", 40'(b_sclk), 40'(e_sclk));
        chk(b_rsp_valid === e_rv, "R10 three-wire rsp_valid", 40'(b_rsp_valid), 40'(e_rv));
    end

    task automatic prep(input logic [39:0] r);
        resp = r; fall_n = 0; in_xfer = 1'b0; cap = '0;
    endtask

    task automatic do_cmd(input logic wr, input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_write = wr; cmd_addr = a; cmd_wdata = d;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_ready();
        int n = 0;
        while (!cmd_ready && n < 2000) begin @(negedge clk); n++; end
    endtask

    task automatic wait_rsp(input int c0);
        int n = 0;
        while (rsp_cnt == c0 && n < 2000) begin @(negedge clk); n++; end
        @(negedge clk);
    endtask

    task automatic reg_read(input logic [5:0] a, input logic [31:0] val);
        int nb, c0;
        logic [39:0] mask;
        nb   = nbytes_of(a);
        mask = (40'h1 << (8 * nb)) - 40'h1;
        prep({8'h5A, val << (32 - 8 * nb)});
        c0 = rsp_cnt;
        do_cmd(1'b0, a, 32'h0);
        wait_ready();
        chk(rsp_cnt == c0 + 1, "R8 one read strobe", 40'(rsp_cnt - c0), 40'(1));
        chk(last_rsp == val, "R4 read data", 40'(last_rsp), 40'(val));
        chk(last_conv == 1'b0, "R8 command read flag", 40'(last_conv), 40'(0));
        chk(fall_n == 8 + 8 * nb, "R5 frame length", 40'(fall_n), 40'(8 + 8 * nb));
        chk(((cap >> (8 * nb)) & 40'hFF) == 40'({2'b01, a}), "R3 read command byte",
            (cap >> (8 * nb)) & 40'hFF, 40'({2'b01, a}));
        chk((cap & mask) == 40'h0, "R4 mosi zero in read data", cap & mask, 40'h0);
    endtask

    task automatic reg_write(input logic [5:0] a, input logic [31:0] d);
        int nb, c0;
        logic [39:0] mask;
        nb   = nbytes_of(a);
        mask = (40'h1 << (8 * nb)) - 40'h1;
        prep(40'h0);
        c0 = rsp_cnt;
        do_cmd(1'b1, a, d);
        wait_ready();
        chk(rsp_cnt == c0, "R6 no strobe on write", 40'(rsp_cnt - c0), 40'(0));
        chk(fall_n == 8 + 8 * nb, "R5 write frame length", 40'(fall_n), 40'(8 + 8 * nb));
        chk(((cap >> (8 * nb)) & 40'hFF) == 40'({2'b00, a}), "R3 write command byte",
            (cap >> (8 * nb)) & 40'hFF, 40'({2'b00, a}));
        chk((cap & mask) == (40'(d) & mask), "R6 write data", cap & mask, 40'(d) & mask);
    endtask

    initial begin
        int c0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(cs_n == 1'b1 && sclk == 1'b1 && mosi == 1'b1, "R1 pins after reset",
            40'({cs_n, sclk, mosi}), 40'h7);
        chk(rsp_valid == 1'b0 && cmd_ready == 1'b1, "R1 handshake after reset",
            40'({rsp_valid, cmd_ready}), 40'h1);

        reg_read(6'h12, 32'h0000A5C3);
        reg_read(6'h00, 32'h00000081);
        reg_read(6'h35, 32'h00C0FFEE);
        reg_write(6'h01, 32'h1234BEEF);
        reg_write(6'h3A, 32'hAB123456);

        // R7 stale low line at the start of waiting must not start a read
        prep({8'hFF, 32'hDEADBEEF});
        @(negedge clk); rdy_line = 1'b0; conv_en = 1'b1;
        repeat (20) @(negedge clk);
        chk(fall_n == 0 && cmd_ready == 1'b1, "R7 stale low ignored", 40'(fall_n), 40'(0));
        rdy_line = 1'b1; repeat (3) @(negedge clk);
        c0 = rsp_cnt;
        rdy_line = 1'b0;
        wait_rsp(c0);
        chk(last_rsp == 32'hDEADBEEF, "R7 conversion result", 40'(last_rsp), 40'hDEADBEEF);
        chk(last_conv == 1'b1, "R8 conversion flag", 40'(last_conv), 40'(1));
        chk(cap[39:32] == 8'h44, "R7 result register command", 40'(cap[39:32]), 40'h44);
        rdy_line = 1'b1; in_xfer = 1'b0;

        // R9 command and ready edge on the same clock: the write goes first
        prep(40'h0);
        repeat (4) @(negedge clk);
        c0 = rsp_cnt;
        cmd_valid = 1'b1; cmd_write = 1'b1; cmd_addr = 6'h02; cmd_wdata = 32'h0000C3A5;
        rdy_line  = 1'b0;
        @(negedge clk); cmd_valid = 1'b0;
        wait_ready();
        chk(cap[23:0] == 24'h02C3A5, "R9 write served first", 40'(cap[23:0]), 40'h02C3A5);
        repeat (20) @(negedge clk);
        chk(rsp_cnt == c0 && cmd_ready == 1'b1, "R9 waits for a new edge", 40'(rsp_cnt - c0), 40'(0));
        prep({8'hFF, 32'h00000001});
        rdy_line = 1'b1; repeat (3) @(negedge clk);
        rdy_line = 1'b0;
        wait_rsp(c0);
        chk(last_rsp == 32'h1 && last_conv == 1'b1, "R9 result after resume", 40'(last_rsp), 40'h1);
        rdy_line = 1'b1; in_xfer = 1'b0;

        // R12 leaving the waiting state
        repeat (3) @(negedge clk);
        conv_en = 1'b0;
        repeat (3) @(negedge clk);
        chk(cs_n == 1'b1, "R12 cs_n high when idle", 40'(cs_n), 40'(1));
        chk(b_cs_n == 1'b0, "R10 three-wire select held", 40'(b_cs_n), 40'(0));
        prep(40'h0);
        rdy_line = 1'b0; repeat (10) @(negedge clk);
        chk(fall_n == 0 && rsp_cnt == c0 + 1, "R12 line ignored when idle", 40'(fall_n), 40'(0));
        rdy_line = 1'b1;
        reg_read(6'h04, 32'h80000001);

        repeat (5) @(negedge clk);
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule